// File: doc/BRIEF.md
# Message Trace Capture Filter

This block sits beside an inter-station message fabric and watches every message that goes past. Each message carries a 12-bit source station id, a 12-bit destination station id and a payload. When tracing is on and the message passes the id filter, the block raises a write request carrying one trace record: the two ids and the payload. The record is addressed at the current slot of a trace window that lies between a programmable base address and a programmable limit address.

The block never stalls the message stream. If the memory side is not ready when a matching message arrives, that message is lost and a saturating drop counter counts it. When the window is used up, the block follows the wrap bit. With wrap set it continues from the base. With wrap clear it stops and holds a sticky full flag until software rewrites the base. The current write pointer is brought out so that software can read it.

Top module: `msg_trace_filter`

## Requirements
- R1: After reset the write pointer is 0, the full flag is 0, the drop count is 0 and no write request is raised, whatever the message inputs carry.
- R2: The configuration word is written with `cfg_wr`. Bit 0 enables tracing. While bit 0 is clear, no write request is raised and no drop is counted.
- R3: Config bit 23 enables source matching against the id in bits [19:8]. While it is set, a message whose source id differs from that id is not captured.
- R4: Config bit 39 enables destination matching against the id in bits [35:24]. While it is set, a message whose destination id differs from that id is not captured.
- R5: A comparison whose enable bit is clear counts as a match. With both clear, every message is captured while tracing is enabled.
- R6: A captured message raises `wr_valid` combinationally in the same cycle as `msg_valid`. In that cycle `wr_addr` equals the write pointer and `wr_data` is {source id [55:44], destination id [43:32], payload [31:0]}.
- R7: At each clock edge where `wr_valid` and `wr_ready` are both high, the pointer advances by one, unless it was at the limit.
- R8: Config bit 1 selects wrap. With wrap set, a write accepted at the limit address returns the pointer to the base.
- R9: With wrap clear, a write accepted at the limit address sets `full`. The pointer stays at the limit, and no further write request is raised while `full` is high.
- R10: Writing the base register loads the pointer with the new base and clears `full` on the next edge. This takes priority over an accepted write in the same cycle.
- R11: A captured message that meets `wr_ready` low is dropped. The pointer does not move, and the drop count rises by one on the next edge, saturating at its maximum (255).
- R12: A message that fails the filter, or that arrives while `full` is high, does not change the drop count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_data | input | 40 | Configuration word (enable, wrap, ids, match enables) |
| base_wr | input | 1 | Write strobe for the window base |
| base_data | input | 16 | Window base address |
| limit_wr | input | 1 | Write strobe for the window limit |
| limit_data | input | 16 | Window limit address (last slot) |
| msg_valid | input | 1 | A message is present this cycle |
| msg_src | input | 12 | Source station id |
| msg_dst | input | 12 | Destination station id |
| msg_payload | input | 32 | Message payload |
| wr_valid | output | 1 | Trace record write request |
| wr_ready | input | 1 | Memory side accepts the request |
| wr_addr | output | 16 | Slot address of the record |
| wr_data | output | 56 | Trace record |
| wr_ptr | output | 16 | Current write pointer |
| full | output | 1 | Sticky window-exhausted flag |
| drop_count | output | 8 | Saturating count of dropped messages |

## Verification
The write request, address and record are combinational, so the bench drives each message just after a falling edge and samples `wr_valid`, `wr_addr` and `wr_data` one time unit later, before the next rising edge. The pointer, full flag and drop count are registered one edge after the message or strobe, so the bench reads them at the following falling edge. It tracks the expected pointer from the window bounds and the wrap bit it has programmed. Register writes count as settled one edge after their strobe.

// File: rtl/msg_trace_pkg.sv
// Shared types for the message trace filter.
// Assumes 12-bit station ids and a 40-bit configuration word.
package msg_trace_pkg;
    localparam int ID_W  = 12;
    localparam int CFG_W = 40;

    typedef struct packed {
        logic            dst_chk;
        logic [ID_W-1:0] dst_id;
        logic            src_chk;
        logic [ID_W-1:0] src_id;
        logic            wrap;
        logic            enable;
    } trace_cfg_t;

    // Pull the fields out of the raw configuration word.
    function automatic trace_cfg_t unpack_cfg(input logic [CFG_W-1:0] raw);
        trace_cfg_t c;
        c.enable  = raw[0];
        c.wrap    = raw[1];
        c.src_id  = raw[19:8];
        c.src_chk = raw[23];
        c.dst_id  = raw[35:24];
        c.dst_chk = raw[39];
        return c;
    endfunction
endpackage

// File: rtl/trace_id_match.sv
// Id filter: passes a message when each enabled id comparison agrees.
// Assumes: purely combinational. A disabled comparison counts as a pass.
module trace_id_match
    import msg_trace_pkg::*;
(
    input  trace_cfg_t      cfg,
    input  logic [ID_W-1:0] src,
    input  logic [ID_W-1:0] dst,
    output logic            pass
);
    logic src_ok;
    logic dst_ok;

    // Each comparison is forced true when its enable is clear.
    always_comb begin
        src_ok = !cfg.src_chk || (src == cfg.src_id);
        dst_ok = !cfg.dst_chk || (dst == cfg.dst_id);
        pass   = src_ok && dst_ok;
    end
endmodule

// File: rtl/trace_wptr.sv
// Window write pointer with base register, wrap or stop at the limit, and a sticky full flag.
// Assumes: base_wr has priority over adv; adv is only raised when full is low.
module trace_wptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_wr,
    input  logic [AW-1:0] base_in,
    input  logic [AW-1:0] limit,
    input  logic          wrap,
    input  logic          adv,
    output logic [AW-1:0] ptr,
    output logic          full
);
    logic [AW-1:0] base_q;
    logic          at_limit;

    assign at_limit = (ptr == limit);

    // Hold the base address that software last wrote.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_wr) base_q <= base_in;
    end

    // Move the pointer: reload on a base write, else step, wrap or stop on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            full <= 1'b0;
        end else if (base_wr) begin
            ptr  <= base_in;
            full <= 1'b0;
        end else if (adv) begin
            if (at_limit) begin
                if (wrap) ptr  <= base_q;
                else      full <= 1'b1;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    // R9
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && !base_wr |=> full);
    // R10
    base_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> (ptr == $past(base_in)) && !full);
    // R8
    wrap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !base_wr && at_limit && wrap |=> ptr == $past(base_q));
    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !base_wr && at_limit && !wrap |=> full && $stable(ptr));
endmodule

// File: rtl/trace_drop_ctr.sv
// Saturating counter of matching messages lost to a busy write port.
// Assumes: inc is at most one per cycle.
module trace_drop_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] MAXV = '1;

    // Count up by one per drop and stop at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                    count <= '0;
        else if (inc && count != MAXV) count <= count + 1'b1;
    end

    // R11
    drop_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count >= $past(count));
    // R12
    drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
endmodule

// File: rtl/msg_trace_filter.sv
// Trace capture filter: watches a message stream, filters it by source and destination id,
// and issues one write request per captured message into a base/limit window.
// Assumes: the message stream cannot be stalled; a busy write port costs a dropped message.
module msg_trace_filter
    import msg_trace_pkg::*;
#(
    parameter int AW  = 16,
    parameter int PW  = 32,
    parameter int DCW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [CFG_W-1:0]        cfg_data,
    input  logic                    base_wr,
    input  logic [AW-1:0]           base_data,
    input  logic                    limit_wr,
    input  logic [AW-1:0]           limit_data,
    input  logic                    msg_valid,
    input  logic [ID_W-1:0]         msg_src,
    input  logic [ID_W-1:0]         msg_dst,
    input  logic [PW-1:0]           msg_payload,
    output logic                    wr_valid,
    input  logic                    wr_ready,
    output logic [AW-1:0]           wr_addr,
    output logic [2*ID_W+PW-1:0]    wr_data,
    output logic [AW-1:0]           wr_ptr,
    output logic                    full,
    output logic [DCW-1:0]          drop_count
);
    localparam logic [DCW-1:0] DROP_MAX = '1;

    trace_cfg_t    cfg_q;
    logic [AW-1:0] limit_q;
    logic          id_pass;
    logic          accept;
    logic          drop;

    // Latch the configuration word as decoded fields.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= unpack_cfg(cfg_data);
    end

    // Hold the window limit address.
    always_ff @(posedge clk) begin
        if (!rst_n)        limit_q <= '0;
        else if (limit_wr) limit_q <= limit_data;
    end

    trace_id_match u_match (
        .cfg  (cfg_q),
        .src  (msg_src),
        .dst  (msg_dst),
        .pass (id_pass)
    );

    // Raise the write request and split it into accepted or dropped.
    always_comb begin
        wr_valid = msg_valid && cfg_q.enable && id_pass && !full;
        accept   = wr_valid && wr_ready;
        drop     = wr_valid && !wr_ready;
        wr_addr  = wr_ptr;
        wr_data  = {msg_src, msg_dst, msg_payload};
    end

    trace_wptr #(.AW(AW)) u_wptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_wr (base_wr),
        .base_in (base_data),
        .limit   (limit_q),
        .wrap    (cfg_q.wrap),
        .adv     (accept),
        .ptr     (wr_ptr),
        .full    (full)
    );

    trace_drop_ctr #(.CW(DCW)) u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (drop),
        .count (drop_count)
    );

    // R9
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_valid);
    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.enable |-> !wr_valid);
    // R11
    drop_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready && drop_count != DROP_MAX && !base_wr
        |=> drop_count == $past(drop_count) + 1'b1 && wr_ptr == $past(wr_ptr));
    // R7
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && !base_wr && wr_ptr != limit_q
        |=> wr_ptr == $past(wr_ptr) + 1'b1);
endmodule

// File: tb/msg_trace_filter_tb_top.sv
module msg_trace_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [39:0] cfg_data = '0;
    logic        base_wr = 1'b0;
    logic [15:0] base_data = '0;
    logic        limit_wr = 1'b0;
    logic [15:0] limit_data = '0;
    logic        msg_valid = 1'b0;
    logic [11:0] msg_src = '0;
    logic [11:0] msg_dst = '0;
    logic [31:0] msg_payload = '0;
    logic        wr_ready = 1'b1;
    logic        wr_valid;
    logic [15:0] wr_addr;
    logic [55:0] wr_data;
    logic [15:0] wr_ptr;
    logic        full;
    logic [7:0]  drop_count;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] exp_ptr;
    logic [7:0]  exp_drop;

    always #10 clk = ~clk;

    msg_trace_filter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .base_wr(base_wr), .base_data(base_data), .limit_wr(limit_wr),
        .limit_data(limit_data), .msg_valid(msg_valid), .msg_src(msg_src),
        .msg_dst(msg_dst), .msg_payload(msg_payload), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ptr(wr_ptr), .full(full), .drop_count(drop_count)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] mk_cfg(input logic en, input logic wrap,
        input logic s_en, input logic [11:0] s_id, input logic d_en, input logic [11:0] d_id);
        logic [39:0] v = '0;
        v[0] = en; v[1] = wrap; v[19:8] = s_id; v[23] = s_en;
        v[35:24] = d_id; v[39] = d_en;
        return v;
    endfunction

    task automatic put_cfg(input logic [39:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_data = v;
        @(posedge clk); #1 cfg_wr = 1'b0;
    endtask

    task automatic put_base(input logic [15:0] v);
        @(negedge clk); base_wr = 1'b1; base_data = v;
        @(posedge clk); #1 base_wr = 1'b0;
        exp_ptr = v;
    endtask

    task automatic put_limit(input logic [15:0] v);
        @(negedge clk); limit_wr = 1'b1; limit_data = v;
        @(posedge clk); #1 limit_wr = 1'b0;
    endtask

    // Present one message; check the request in-cycle; exp_req says whether it should be raised.
    task automatic send(input string tag, input logic [11:0] s, input logic [11:0] d,
                        input logic [31:0] p, input logic rdy, input logic exp_req);
        @(negedge clk);
        msg_valid = 1'b1; msg_src = s; msg_dst = d; msg_payload = p; wr_ready = rdy;
        #1;
        check({tag, " req"}, 64'(wr_valid), 64'(exp_req));
        if (exp_req) begin
            check({tag, " addr"}, 64'(wr_addr), 64'(exp_ptr));
            check({tag, " data"}, 64'(wr_data), 64'({s, d, p}));
        end
        @(posedge clk); #1;
        msg_valid = 1'b0; wr_ready = 1'b1;
    endtask

    task automatic check_state(input string tag, input logic exp_full);
        @(negedge clk);
        check({tag, " ptr"}, 64'(wr_ptr), 64'(exp_ptr));
        check({tag, " full"}, 64'(full), 64'(exp_full));
        check({tag, " drops"}, 64'(drop_count), 64'(exp_drop));
    endtask

    task automatic t_reset;
        exp_ptr = '0; exp_drop = '0;
        @(negedge clk); msg_valid = 1'b1; wr_ready = 1'b0; #1;
        check("R1 reset req", 64'(wr_valid), 64'd0);
        check("R1 reset ptr", 64'(wr_ptr), 64'd0);
        check("R1 reset full", 64'(full), 64'd0);
        check("R1 reset drops", 64'(drop_count), 64'd0);
        @(posedge clk); #1 msg_valid = 1'b0; wr_ready = 1'b1;
    endtask

    task automatic t_disabled;
        put_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 12'h0, 1'b0, 12'h0));
        send("R2 disabled", 12'h001, 12'h002, 32'h11, 1'b0, 1'b0);
        check_state("R2 R12 disabled", 1'b0);
    endtask

    task automatic t_all_match;
        put_limit(16'h0103);
        put_base(16'h0100);
        put_cfg(mk_cfg(1'b1, 1'b0, 1'b0, 12'h0, 1'b0, 12'h0));
        send("R5 R6 any0", 12'hFFF, 12'h000, 32'hDEAD_BEEF, 1'b1, 1'b1);
        exp_ptr++;
        check_state("R7 step0", 1'b0);
        send("R5 R6 any1", 12'h123, 12'h456, 32'h0BAD_F00D, 1'b1, 1'b1);
        exp_ptr++;
        check_state("R7 step1", 1'b0);
    endtask

    task automatic t_src_filter;
        put_base(16'h0100);
        put_cfg(mk_cfg(1'b1, 1'b0, 1'b1, 12'h0AB, 1'b0, 12'h0));
        send("R3 src hit", 12'h0AB, 12'h777, 32'h1, 1'b1, 1'b1);
        exp_ptr++;
        send("R3 src miss", 12'h0AC, 12'h777, 32'h2, 1'b0, 1'b0);
        check_state("R3 R12 src", 1'b0);
    endtask

    task automatic t_dst_filter;
        put_cfg(mk_cfg(1'b1, 1'b0, 1'b0, 12'h0, 1'b1, 12'h5C3));
        send("R4 dst hit", 12'h010, 12'h5C3, 32'h3, 1'b1, 1'b1);
        exp_ptr++;
        send("R4 dst miss", 12'h010, 12'h5C2, 32'h4, 1'b0, 1'b0);
        check_state("R4 R12 dst", 1'b0);
        put_cfg(mk_cfg(1'b1, 1'b0, 1'b1, 12'h0AB, 1'b1, 12'h5C3));
        send("R3 R4 both hit", 12'h0AB, 12'h5C3, 32'h5, 1'b1, 1'b1);
        exp_ptr++;
        send("R3 R4 one miss", 12'h0AB, 12'h5C4, 32'h6, 1'b1, 1'b0);
        check_state("R3 R4 both", 1'b0);
    endtask

    task automatic t_stop;
        put_cfg(mk_cfg(1'b1, 1'b0, 1'b0, 12'h0, 1'b0, 12'h0));
        put_base(16'h0100);
        for (int i = 0; i < 4; i++) begin
            send("R9 fill", 12'h001, 12'h002, 32'(i), 1'b1, 1'b1);
            if (i < 3) exp_ptr++;
        end
        check_state("R9 stop", 1'b1);
        send("R9 after full", 12'h001, 12'h002, 32'h9, 1'b0, 1'b0);
        check_state("R9 R12 full", 1'b1);
    endtask

    task automatic t_base_prio;
        @(negedge clk);
        base_wr = 1'b1; base_data = 16'h0200;
        #1 check("R9 full blocks", 64'(wr_valid), 64'd0);
        @(posedge clk); #1 base_wr = 1'b0;
        exp_ptr = 16'h0200;
        check_state("R10 clear", 1'b0);
        // base write coinciding with an accepted write
        @(negedge clk);
        base_wr = 1'b1; base_data = 16'h0200;
        msg_valid = 1'b1; msg_src = 12'h3; msg_dst = 12'h4; wr_ready = 1'b1;
        #1 check("R10 prio req", 64'(wr_valid), 64'd1);
        @(posedge clk); #1 base_wr = 1'b0; msg_valid = 1'b0;
        check_state("R10 prio", 1'b0);
    endtask

    task automatic t_wrap;
        put_limit(16'h0201);
        put_cfg(mk_cfg(1'b1, 1'b1, 1'b0, 12'h0, 1'b0, 12'h0));
        send("R8 w0", 12'h1, 12'h2, 32'hA0, 1'b1, 1'b1);
        exp_ptr = 16'h0201;
        send("R8 w1", 12'h1, 12'h2, 32'hA1, 1'b1, 1'b1);
        exp_ptr = 16'h0200;
        check_state("R8 wrapped", 1'b0);
        send("R8 w2", 12'h1, 12'h2, 32'hA2, 1'b1, 1'b1);
        exp_ptr = 16'h0201;
        check_state("R8 after", 1'b0);
    endtask

    task automatic t_drop;
        send("R11 stall", 12'h5, 12'h6, 32'hC0, 1'b0, 1'b1);
        exp_drop++;
        check_state("R11 drop1", 1'b0);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); msg_valid = 1'b1; wr_ready = 1'b0;
            @(posedge clk); #1;
        end
        msg_valid = 1'b0; wr_ready = 1'b1;
        exp_drop = 8'hFF;
        check_state("R11 saturate", 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_disabled();
        t_all_match();
        t_src_filter();
        t_dst_filter();
        t_stop();
        t_base_prio();
        t_wrap();
        t_drop();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule